// File: doc/BRIEF.md
# Bit-Serial Word Adder

This block adds two binary operands that are streamed into it one bit per clock, least significant bit first, and returns the sum as a stream of the same shape. Its datapath is one full-adder cell and one flip-flop that keeps the carry between consecutive bit positions. It takes a full word length in cycles to add one word pair. In exchange, the cost is a handful of gates and no word-wide register.

Word boundaries travel in-band. A `first_in` strobe accompanies bit 0 of each operand pair. In that cycle the carry that was left over from the previous word is discarded and the addition starts from zero. Words can therefore follow one another with no idle cycle between them. The sum bit, a delayed copy of the strobe and a valid flag leave through registers one cycle after the operand bits that produced them. The block does not pack or unpack words.

Top module: `serial_adder_top`

## Requirements
- R1: For each bit cycle the output sum bit equals a XOR b XOR c, where c is the carry-in in force, and the stored carry becomes the majority of a, b and c. A word streamed LSB first therefore yields a + b modulo 2^N.
- R2: In any cycle with `first_in` = 1 the carry-in is 0 whatever value is stored. The carry produced in that cycle is stored as usual.
- R3: `sum_out` presents the result of the operand bits sampled at a rising edge, starting from that edge and holding until the next edge. Changing the inputs between edges does not alter `sum_out`.
- R4: `sum_first` is `first_in` delayed by one cycle, so it is 1 exactly when `sum_out` carries bit 0 of a word.
- R5: A rising edge with `rst_n` = 0 clears `sum_out`, `sum_first`, `sum_valid` and the stored carry. The first bit accepted after reset without a strobe therefore sees a carry-in of 0.
- R6: `sum_valid` is 0 from reset until the output of the first strobed bit appears. It then stays 1 until the next reset.
- R7: Words that follow each other with no gap are each summed correctly. The carry out of the top bit of one word never reaches the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| a_bit | input | 1 | Operand A, one bit per cycle, LSB first |
| b_bit | input | 1 | Operand B, one bit per cycle, LSB first |
| first_in | input | 1 | Strobe marking bit 0 of a word pair |
| sum_out | output | 1 | Registered sum bit |
| sum_first | output | 1 | Registered strobe, marks bit 0 of a sum word |
| sum_valid | output | 1 | High once the stream has started since reset |

## Verification
The only internal state that affects arithmetic is the stored carry. If that carry is wrong, `sum_out` flips in the cycle that follows. If a stale carry survives a word boundary, bit 0 of the next sum is wrong, and this shows one cycle after the strobe. Pairs such as 0xFF + 0x01 followed by 0x00 + 0x00 leave a carry pending at the boundary, so a missing clear appears straight away. A reset that fails to clear the carry appears one cycle after the first unstrobed bit following reset. Faults in the strobe or valid registers show on `sum_first` and `sum_valid` at the next edge.

// File: rtl/sadd_pkg.sv
// Shared types for the bit-serial adder.
// Assumes: one operand bit per lane per cycle.
package sadd_pkg;

    // Result of one full-adder evaluation.
    typedef struct packed {
        logic sum;
        logic carry;
    } fa_result_t;

    // Output-stage register contents.
    typedef struct packed {
        logic sum;
        logic first;
        logic valid;
    } out_regs_t;

endpackage

// File: rtl/sadd_full_adder.sv
// One-bit full adder.
// Produces sum = a ^ b ^ c and carry = majority(a, b, c).
// Assumes: purely combinational; the caller supplies the carry-in in force.
module sadd_full_adder
    import sadd_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       c_i,
    output fa_result_t res_o
);

    logic half_x;

    // Evaluate the sum and majority carry.
    always_comb begin
        half_x      = a_i ^ b_i;
        res_o.sum   = half_x ^ c_i;
        res_o.carry = (a_i & b_i) | (half_x & c_i);
    end

endmodule

// File: rtl/sadd_carry_store.sv
// Carry flip-flop with in-band clear.
// When first_i is set, the carry offered to the adder is forced to 0 and the
// stored value is ignored. The new carry is captured every cycle.
// Assumes: synchronous active-low reset.
module sadd_carry_store (
    input  logic clk,
    input  logic rst_n,
    input  logic first_i,
    input  logic carry_next_i,
    output logic carry_in_o
);

    logic carry_q;

    // Pick the carry-in in force for this bit.
    always_comb carry_in_o = first_i ? 1'b0 : carry_q;

    // Hold the carry between bit positions.
    always_ff @(posedge clk) begin
        if (!rst_n) carry_q <= 1'b0;
        else        carry_q <= carry_next_i;
    end

endmodule

// File: rtl/sadd_out_stage.sv
// Output registers: sum bit, delayed word strobe and a sticky valid flag.
// Assumes: synchronous active-low reset; valid rises once a strobe is seen.
module sadd_out_stage
    import sadd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sum_i,
    input  logic      first_i,
    output out_regs_t regs_o
);

    out_regs_t regs_q;

    // Capture the outputs for this bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q.sum   <= sum_i;
            regs_q.first <= first_i;
            regs_q.valid <= regs_q.valid | first_i;
        end
    end

    // Present the registered values.
    always_comb regs_o = regs_q;

endmodule

// File: rtl/serial_adder_top.sv
// Bit-serial adder, LSB first, one bit per clock.
// first_in marks bit 0 of each word and clears the carry in-band.
// Assumes: words arrive back to back or with gaps, with no length limit;
// outputs lag the inputs by one cycle.
module serial_adder_top
    import sadd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_bit,
    input  logic b_bit,
    input  logic first_in,
    output logic sum_out,
    output logic sum_first,
    output logic sum_valid
);

    logic       carry_in;
    fa_result_t fa_res;
    out_regs_t  out_regs;

    sadd_carry_store u_carry (
        .clk          (clk),
        .rst_n        (rst_n),
        .first_i      (first_in),
        .carry_next_i (fa_res.carry),
        .carry_in_o   (carry_in)
    );

    sadd_full_adder u_fa (
        .a_i   (a_bit),
        .b_i   (b_bit),
        .c_i   (carry_in),
        .res_o (fa_res)
    );

    sadd_out_stage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .sum_i   (fa_res.sum),
        .first_i (first_in),
        .regs_o  (out_regs)
    );

    // Drive the ports from the output registers.
    always_comb begin
        sum_out   = out_regs.sum;
        sum_first = out_regs.first;
        sum_valid = out_regs.valid;
    end

endmodule

// File: rtl/sadd_checker.sv
// Port-level properties of the bit-serial adder, bound to the top module.
// Assumes: the reset is synchronous and active low.
module sadd_checker (
    input logic clk,
    input logic rst_n,
    input logic a_bit,
    input logic b_bit,
    input logic first_in,
    input logic sum_out,
    input logic sum_first,
    input logic sum_valid
);

    AST_STROBE_ZERO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        first_in |=> (sum_out == $past(a_bit ^ b_bit))); // R2

    AST_CARRY_PROPAGATES: assert property (@(posedge clk) disable iff (!rst_n)
        (first_in && a_bit && b_bit) ##1 (!first_in && !a_bit && !b_bit) |=> sum_out); // R1

    AST_STROBE_DELAY_HI: assert property (@(posedge clk) disable iff (!rst_n)
        first_in |=> sum_first); // R4

    AST_STROBE_DELAY_LO: assert property (@(posedge clk) disable iff (!rst_n)
        !first_in |=> !sum_first); // R4

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid |=> sum_valid); // R6

    AST_VALID_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sum_valid && !first_in) |=> !sum_valid); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!sum_out && !sum_first && !sum_valid)); // R5

endmodule

bind serial_adder_top sadd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_bit     (a_bit),
    .b_bit     (b_bit),
    .first_in  (first_in),
    .sum_out   (sum_out),
    .sum_first (sum_first),
    .sum_valid (sum_valid)
);

// File: tb/sim_serial_adder_top.sv
module sim_serial_adder_top;

    localparam int W      = 8;
    localparam int NVEC   = 10;
    localparam int NRAND  = 30;
    localparam int MAXW   = 64;

    // Table of operand pairs {a, b}
    localparam logic [2*W-1:0] VEC [0:NVEC-1] = '{
        {8'hFF, 8'h01}, {8'h00, 8'h00}, {8'h80, 8'h80}, {8'h55, 8'hAA},
        {8'hFF, 8'hFF}, {8'h0F, 8'h01}, {8'h7F, 8'h01}, {8'h01, 8'h01},
        {8'hAA, 8'hAA}, {8'h00, 8'hFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_bit = 1'b0;
    logic b_bit = 1'b0;
    logic first_in = 1'b0;
    logic sum_out, sum_first, sum_valid;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [W-1:0] exp_q [0:MAXW-1];
    int exp_n = 0;
    int got_n = 0;
    int pos = W;
    logic [W-1:0] acc = '0;
    bit collect_en = 1'b0;

    always #2.5 clk = ~clk;

    serial_adder_top u0 (
        .clk(clk), .rst_n(rst_n), .a_bit(a_bit), .b_bit(b_bit),
        .first_in(first_in), .sum_out(sum_out), .sum_first(sum_first),
        .sum_valid(sum_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reassemble sum words away from the active edge (R1, R7)
    always @(negedge clk) begin
        if (collect_en && sum_valid) begin
            if (sum_first) pos = 0;
            if (pos < W) begin
                acc[pos] = sum_out;
                pos++;
                if (pos == W) begin
                    check(acc == exp_q[got_n], "R1/R7 word sum", int'(acc), int'(exp_q[got_n]));
                    got_n++;
                end
            end
        end
    end

    task automatic send_word(input logic [W-1:0] a, input logic [W-1:0] b);
        exp_q[exp_n] = a + b;
        exp_n++;
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            a_bit = a[i];
            b_bit = b[i];
            first_in = (i == 0);
        end
    endtask

    task automatic drive(input logic a, input logic b, input logic f);
        @(negedge clk);
        a_bit = a; b_bit = b; first_in = f;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R5: reset state, with inputs active during reset
        a_bit = 1'b1; first_in = 1'b1;
        repeat (3) @(negedge clk);
        check(sum_out == 0, "R5 sum_out in reset", sum_out, 0);
        check(sum_first == 0, "R5 sum_first in reset", sum_first, 0);
        check(sum_valid == 0, "R5 sum_valid in reset", sum_valid, 0);

        // R5: carry cleared by reset -> 1+0 without strobe gives 1
        a_bit = 1'b1; b_bit = 1'b0; first_in = 1'b0; rst_n = 1'b1;
        drive(1'b0, 1'b0, 1'b0);
        check(sum_out == 1, "R5 carry cleared by reset", sum_out, 1);
        // R6: no strobe yet -> not valid
        check(sum_valid == 0, "R6 valid before strobe", sum_valid, 0);

        // R3: inputs changed between edges leave output unchanged
        drive(1'b1, 1'b0, 1'b1);
        #1;
        check(sum_out == 0, "R3 output holds between edges", sum_out, 0);
        a_bit = 1'b0; #1; a_bit = 1'b1;
        drive(1'b1, 1'b1, 1'b1); // builds carry 1
        check(sum_out == 1, "R3 sum one cycle later", sum_out, 1);
        check(sum_first == 1, "R4 strobe delayed", sum_first, 1);
        check(sum_valid == 1, "R6 valid after strobe", sum_valid, 1);

        // R2: strobe ignores stored carry (carry=1 now)
        drive(1'b0, 1'b0, 1'b1);
        check(sum_out == 0, "R2 prior bit 1+1 sum", sum_out, 0);
        drive(1'b0, 1'b0, 1'b0);
        check(sum_out == 0, "R2 strobe forces carry-in 0", sum_out, 0);
        check(sum_first == 1, "R4 strobe delayed again", sum_first, 1);
        drive(1'b0, 1'b0, 1'b0);
        check(sum_first == 0, "R4 strobe low follows", sum_first, 0);
        check(sum_valid == 1, "R6 valid sticky", sum_valid, 1);

        // R5: reset with a pending carry
        drive(1'b1, 1'b1, 1'b1);
        @(negedge clk); rst_n = 1'b0; a_bit = 0; b_bit = 0; first_in = 0;
        @(negedge clk);
        check(sum_valid == 0, "R5 valid cleared", sum_valid, 0);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 1'b0);
        check(sum_out == 0, "R5 pending carry cleared", sum_out, 0);

        // R1, R7: table then random words, back to back
        collect_en = 1'b1;
        for (int v = 0; v < NVEC; v++) send_word(VEC[v][2*W-1:W], VEC[v][W-1:0]);
        for (int r = 0; r < NRAND; r++) send_word(W'($urandom), W'($urandom));
        drive(1'b0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        collect_en = 1'b0;
        check(got_n == exp_n, "R7 word count", got_n, exp_n);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule